// File: doc/BRIEF.md
# Processor Trap Entry Controller

This block sits beside the pipeline of a 32-bit soft processor. It decides when a pending trap is taken and performs the entry sequence. Four request sources compete: a level interrupt request, a hardware-break request, a hardware-exception request with a cause code, and an MMU fault with its fault kind, access type and faulting address. The pipeline also supplies the PC of the trapping instruction, the pending branch target, and three instruction-state flags: delay slot, pending immediate prefix, and branch-with-immediate.

The block owns the machine-status register (MSR), the exception-status register (ESR), the branch-target register (BTR) and the exception-address register (EAR). At most one entry is taken per clock edge. On that edge the block registers the vector PC, the index and value of the return register to write, and the updated status registers. It also raises `taken_o` for one cycle. The pipeline uses that pulse to flush, to clear its instruction flags, to invalidate the load/store reservation and to write the return register. The pipeline writes the MSR through a plain write port, both for move-to-status instructions and for returns from a trap.

MSR field positions used throughout:
- IE = bit 1
- BIP = bit 3
- EIP = bit 9
- UM = bit 11
- UMS = bit 12
- VM = bit 13
- VMS = bit 14

ESR field positions:
- ESR[4:0]: cause code
- ESR[10]: store access
- ESR[12]: delay slot

Top module: `trap_entry_ctrl`

## Requirements
- R1: The registered `pc_o` after an entry is BASE_VEC+0x10 for an interrupt, BASE_VEC+0x18 for a break, and BASE_VEC+0x20 for a hardware exception or an MMU fault.
- R2: An interrupt is taken only when MSR[1] (IE) is 1, MSR[9] (EIP) and MSR[3] (BIP) are 0, and neither `in_dslot_i` nor `imm_pend_i` is set. Otherwise `taken_o` stays 0 and the MSR is unchanged.
- R3: Interrupt entry clears IE and reports return register 14 with the value `pc_i`.
- R4: Break entry sets BIP and reports return register 16 with the value `pc_i`.
- R5: Hardware-exception entry sets EIP and reports register 17 with the value `pc_i`+4. ESR becomes `exc_cause_i` with ESR[12] = `in_dslot_i`. BTR takes `btarget_i` only when `in_dslot_i` is set.
- R6: MMU-fault entry sets EIP and reports register 17. Its value is PC−8 in a delay slot with `br_imm_i`, PC−4 in a delay slot without it, PC−4 with only an immediate prefix pending, and PC otherwise. ESR[12] and BTR follow the same delay-slot rule as in R5.
- R7: On an MMU fault, ESR[4:0] is 17 for an instruction-fetch protection fault, 16 for a data protection fault, 19 for a fetch miss and 18 for a data miss. ESR[10] is 1 for a store. EAR takes `mmu_addr_i`. `mmu_acc_i` encodes 0 as load, 1 as store and 2 as fetch.
- R8: On every entry, VMS takes the old VM and UMS takes the old UM. VM and UM are then cleared.
- R9: `taken_o` is high for exactly one cycle per accepted entry and is low when no request is accepted.
- R10: With EXC_EN = 0, a hardware-exception request causes no entry and no change to MSR or ESR.
- R11: When several requests coincide, only one is taken, in the order MMU fault, hardware exception, break, interrupt.
- R12: An MMU fault that arrives after an MMU entry and before any MSR write with EIP = 0 causes no entry. Instead it sets `fatal_o`, which stays set until reset.
- R13: An MSR write on `msr_we_i` loads `msr_wdata_i` when no entry is taken that cycle. An entry on the same edge overrides the write.
- R14: After reset, `taken_o`, `fatal_o`, MSR, ESR, BTR and EAR are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Level interrupt request |
| brk_i | input | 1 | Hardware-break request |
| exc_i | input | 1 | Hardware-exception request |
| exc_cause_i | input | 5 | Cause code written to ESR[4:0] on exception |
| mmu_fault_i | input | 1 | MMU fault request |
| mmu_miss_i | input | 1 | 1 for a translation miss, 0 for a protection fault |
| mmu_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| mmu_addr_i | input | XLEN | Faulting address |
| pc_i | input | XLEN | PC of the current instruction |
| btarget_i | input | XLEN | Pending branch target |
| in_dslot_i | input | 1 | Current instruction is in a delay slot |
| imm_pend_i | input | 1 | Current instruction follows an immediate prefix |
| br_imm_i | input | 1 | The delayed branch used an immediate prefix |
| msr_we_i | input | 1 | MSR write enable from the pipeline |
| msr_wdata_i | input | XLEN | MSR write data |
| taken_o | output | 1 | One-cycle entry pulse |
| pc_o | output | XLEN | Vector PC of the last entry |
| ra_idx_o | output | 5 | Return register index |
| ra_val_o | output | XLEN | Return register value |
| msr_o | output | XLEN | Machine-status register |
| esr_o | output | XLEN | Exception-status register |
| btr_o | output | XLEN | Branch-target register |
| ear_o | output | XLEN | Exception-address register |
| fatal_o | output | 1 | Sticky nested-MMU-fault error |

## Verification
Every result of an entry is registered. `taken_o`, `pc_o`, the return-register pair, and the new MSR, ESR, BTR and EAR all appear after the first rising edge that samples the request. An MSR write shows on `msr_o` after the edge that samples it, and `fatal_o` rises on the edge that samples the nested fault. The bench drives each stimulus on a falling edge and samples every result on the next falling edge. It then removes the requests, so each request is seen by exactly one edge. Interrupt gating and MMU rewinding are swept over every combination of their status bits and flags.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;

  localparam int ESR_ST = 10;
  localparam int ESR_DS = 12;

  localparam int RA_W = 5;
  localparam logic [RA_W-1:0] RA_IRQ = 5'd14;
  localparam logic [RA_W-1:0] RA_BRK = 5'd16;
  localparam logic [RA_W-1:0] RA_EXC = 5'd17;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [7:0] OFS_IRQ = 8'h10;
  localparam logic [7:0] OFS_BRK = 8'h18;
  localparam logic [7:0] OFS_EXC = 8'h20;

  typedef enum logic [2:0] {
    TRAP_NONE,
    TRAP_IRQ,
    TRAP_BRK,
    TRAP_EXC,
    TRAP_MMU,
    TRAP_FATAL
  } trap_kind_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter bit EXC_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       brk_i,
  input  logic       exc_i,
  input  logic       mmu_i,
  input  logic       ie_i,
  input  logic       eip_i,
  input  logic       bip_i,
  input  logic       dslot_i,
  input  logic       imm_i,
  input  logic       mmu_busy_i,
  output trap_kind_e kind_o
);
  logic exc_eff;
  logic irq_ok;

  generate
    if (EXC_EN) begin : g_exc
      assign exc_eff = exc_i;
    end else begin : g_noexc
      assign exc_eff = 1'b0;
    end
  endgenerate

  assign irq_ok = irq_i && ie_i && !eip_i && !bip_i && !dslot_i && !imm_i;

  always_comb begin
    kind_o = TRAP_NONE;
    if (mmu_i)        kind_o = mmu_busy_i ? TRAP_FATAL : TRAP_MMU;
    else if (exc_eff) kind_o = TRAP_EXC;
    else if (brk_i)   kind_o = TRAP_BRK;
    else if (irq_ok)  kind_o = TRAP_IRQ;
  end

  // lower sources only win when higher ones are idle
  assert_prio_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == TRAP_IRQ |-> !mmu_i && !brk_i && !(EXC_EN && exc_i));
  assert_prio_brk_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == TRAP_BRK |-> !mmu_i && !(EXC_EN && exc_i));
  assert_no_exc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!EXC_EN && !mmu_i) |-> kind_o != TRAP_EXC);
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] BASE_VEC = '0
) (
  input  trap_kind_e      kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            dslot_i,
  input  logic            imm_i,
  input  logic            br_imm_i,
  input  logic            miss_i,
  input  logic [1:0]      acc_i,
  input  logic [4:0]      cause_i,
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] pc_o,
  output logic [RA_W-1:0] ra_idx_o,
  output logic [XLEN-1:0] ra_val_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] esr_o
);
  logic [XLEN-1:0] msr_k;
  logic [XLEN-1:0] mmu_ret;

  always_comb begin
    if (dslot_i)    mmu_ret = pc_i - (br_imm_i ? XLEN'(8) : XLEN'(4));
    else if (imm_i) mmu_ret = pc_i - XLEN'(4);
    else            mmu_ret = pc_i;
  end

  always_comb begin
    msr_k    = msr_i;
    pc_o     = BASE_VEC + XLEN'(OFS_EXC);
    ra_idx_o = RA_EXC;
    ra_val_o = pc_i;
    esr_o    = '0;
    esr_o[ESR_DS] = dslot_i;
    unique case (kind_i)
      TRAP_IRQ: begin
        msr_k[MSR_IE] = 1'b0;
        pc_o     = BASE_VEC + XLEN'(OFS_IRQ);
        ra_idx_o = RA_IRQ;
      end
      TRAP_BRK: begin
        msr_k[MSR_BIP] = 1'b1;
        pc_o     = BASE_VEC + XLEN'(OFS_BRK);
        ra_idx_o = RA_BRK;
      end
      TRAP_EXC: begin
        msr_k[MSR_EIP] = 1'b1;
        ra_val_o   = pc_i + XLEN'(4);
        esr_o[4:0] = cause_i;
      end
      TRAP_MMU: begin
        msr_k[MSR_EIP] = 1'b1;
        ra_val_o   = mmu_ret;
        esr_o[4:0] = {3'b100, miss_i, acc_i == ACC_FETCH};
        esr_o[ESR_ST] = (acc_i == ACC_STORE);
      end
      default: ;
    endcase
    // saved mode moves up one bit, live mode cleared
    msr_o          = msr_k;
    msr_o[MSR_VMS] = msr_k[MSR_VM];
    msr_o[MSR_UMS] = msr_k[MSR_UM];
    msr_o[MSR_VM]  = 1'b0;
    msr_o[MSR_UM]  = 1'b0;
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] BASE_VEC = '0,
  parameter bit              EXC_EN   = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_i,
  input  logic            brk_i,
  input  logic            exc_i,
  input  logic [4:0]      exc_cause_i,
  input  logic            mmu_fault_i,
  input  logic            mmu_miss_i,
  input  logic [1:0]      mmu_acc_i,
  input  logic [XLEN-1:0] mmu_addr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] btarget_i,
  input  logic            in_dslot_i,
  input  logic            imm_pend_i,
  input  logic            br_imm_i,
  input  logic            msr_we_i,
  input  logic [XLEN-1:0] msr_wdata_i,
  output logic            taken_o,
  output logic [XLEN-1:0] pc_o,
  output logic [4:0]      ra_idx_o,
  output logic [XLEN-1:0] ra_val_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] esr_o,
  output logic [XLEN-1:0] btr_o,
  output logic [XLEN-1:0] ear_o,
  output logic            fatal_o
);
  trap_kind_e      kind;
  logic            entry, exc_like;
  logic [XLEN-1:0] pc_n, ra_val_n, msr_n, esr_n;
  logic [RA_W-1:0] ra_idx_n;

  logic            taken_q, fatal_q, busy_q;
  logic [XLEN-1:0] pc_q, ra_val_q, msr_q, esr_q, btr_q, ear_q;
  logic [RA_W-1:0] ra_idx_q;

  trap_arbiter #(.EXC_EN(EXC_EN)) i_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .brk_i      (brk_i),
    .exc_i      (exc_i),
    .mmu_i      (mmu_fault_i),
    .ie_i       (msr_q[MSR_IE]),
    .eip_i      (msr_q[MSR_EIP]),
    .bip_i      (msr_q[MSR_BIP]),
    .dslot_i    (in_dslot_i),
    .imm_i      (imm_pend_i),
    .mmu_busy_i (busy_q),
    .kind_o     (kind)
  );

  trap_target #(.XLEN(XLEN), .BASE_VEC(BASE_VEC)) i_tgt (
    .kind_i   (kind),
    .pc_i     (pc_i),
    .dslot_i  (in_dslot_i),
    .imm_i    (imm_pend_i),
    .br_imm_i (br_imm_i),
    .miss_i   (mmu_miss_i),
    .acc_i    (mmu_acc_i),
    .cause_i  (exc_cause_i),
    .msr_i    (msr_q),
    .pc_o     (pc_n),
    .ra_idx_o (ra_idx_n),
    .ra_val_o (ra_val_n),
    .msr_o    (msr_n),
    .esr_o    (esr_n)
  );

  assign entry    = kind inside {TRAP_IRQ, TRAP_BRK, TRAP_EXC, TRAP_MMU};
  assign exc_like = kind inside {TRAP_EXC, TRAP_MMU};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q  <= 1'b0;
      fatal_q  <= 1'b0;
      busy_q   <= 1'b0;
      pc_q     <= '0;
      ra_idx_q <= '0;
      ra_val_q <= '0;
      msr_q    <= '0;
      esr_q    <= '0;
      btr_q    <= '0;
      ear_q    <= '0;
    end else begin
      taken_q <= entry;
      if (entry) begin
        pc_q     <= pc_n;
        ra_idx_q <= ra_idx_n;
        ra_val_q <= ra_val_n;
        msr_q    <= msr_n;
        if (exc_like) begin
          esr_q <= esr_n;
          if (in_dslot_i) btr_q <= btarget_i;
        end
        if (kind == TRAP_MMU) begin
          ear_q  <= mmu_addr_i;
          busy_q <= 1'b1;
        end
      end else if (msr_we_i) begin
        msr_q <= msr_wdata_i;
        if (!msr_wdata_i[MSR_EIP]) busy_q <= 1'b0;
      end
      if (kind == TRAP_FATAL) fatal_q <= 1'b1;
    end
  end

  assign taken_o  = taken_q;
  assign pc_o     = pc_q;
  assign ra_idx_o = ra_idx_q;
  assign ra_val_o = ra_val_q;
  assign msr_o    = msr_q;
  assign esr_o    = esr_q;
  assign btr_o    = btr_q;
  assign ear_o    = ear_q;
  assign fatal_o  = fatal_q;

  assert_vector_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> pc_o == BASE_VEC + ((ra_idx_o == RA_IRQ) ? XLEN'(OFS_IRQ) :
                                    (ra_idx_o == RA_BRK) ? XLEN'(OFS_BRK) : XLEN'(OFS_EXC)));
  assert_irq_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry && kind == TRAP_IRQ) |-> msr_q[MSR_IE] && !msr_q[MSR_EIP] && !msr_q[MSR_BIP]);
  assert_irq_ie_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && ra_idx_o == RA_IRQ) |-> !msr_o[MSR_IE]);
  assert_exc_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o && ra_idx_o == RA_EXC) |-> msr_o[MSR_EIP]);
  assert_mode_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> !msr_o[MSR_VM] && !msr_o[MSR_UM]);
  assert_fatal_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  assert_fatal_no_entry_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmu_fault_i && busy_q) |=> !taken_o);
endmodule

// File: tb/test_trap_entry_ctrl.sv
module test_trap_entry_ctrl;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 0, brk = 0, exc = 0, mmu = 0, miss = 0, ds = 0, imm = 0, bimm = 0, we = 0;
  logic [4:0]  cause = '0;
  logic [1:0]  acc = '0;
  logic [31:0] addr = '0, pc = '0, bt = '0, wdata = '0;

  logic        taken, fatal, n_taken, n_fatal;
  logic [4:0]  ra_idx, n_ra_idx;
  logic [31:0] pc_o, ra_val, msr, esr, btr, ear;
  logic [31:0] n_pc, n_ra_val, n_msr, n_esr, n_btr, n_ear;

  int nchk = 0, nfail = 0, cycles = 0;
  logic [31:0] exp_btr = '0;

  always #2 clk = ~clk;

  trap_entry_ctrl #(.XLEN(32), .BASE_VEC(BASE), .EXC_EN(1'b1)) i_trap_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .brk_i(brk), .exc_i(exc), .exc_cause_i(cause),
    .mmu_fault_i(mmu), .mmu_miss_i(miss), .mmu_acc_i(acc), .mmu_addr_i(addr), .pc_i(pc),
    .btarget_i(bt), .in_dslot_i(ds), .imm_pend_i(imm), .br_imm_i(bimm), .msr_we_i(we),
    .msr_wdata_i(wdata), .taken_o(taken), .pc_o(pc_o), .ra_idx_o(ra_idx), .ra_val_o(ra_val),
    .msr_o(msr), .esr_o(esr), .btr_o(btr), .ear_o(ear), .fatal_o(fatal));

  trap_entry_ctrl #(.XLEN(32), .BASE_VEC(BASE), .EXC_EN(1'b0)) i_trap_entry_ctrl_noexc (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .brk_i(brk), .exc_i(exc), .exc_cause_i(cause),
    .mmu_fault_i(mmu), .mmu_miss_i(miss), .mmu_acc_i(acc), .mmu_addr_i(addr), .pc_i(pc),
    .btarget_i(bt), .in_dslot_i(ds), .imm_pend_i(imm), .br_imm_i(bimm), .msr_we_i(we),
    .msr_wdata_i(wdata), .taken_o(n_taken), .pc_o(n_pc), .ra_idx_o(n_ra_idx), .ra_val_o(n_ra_val),
    .msr_o(n_msr), .esr_o(n_esr), .btr_o(n_btr), .ear_o(n_ear), .fatal_o(n_fatal));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] shift_mode(input logic [31:0] m);
    logic [31:0] r = m;
    r[14] = m[13];
    r[12] = m[11];
    r[13] = 1'b0;
    r[11] = 1'b0;
    return r;
  endfunction

  task automatic clr_req();
    irq = 0; brk = 0; exc = 0; mmu = 0; ds = 0; imm = 0; bimm = 0; we = 0;
  endtask

  task automatic wr_msr(input logic [31:0] v);
    wdata = v; we = 1;
    @(negedge clk);
    we = 0;
    chk("R13 msr write", msr, v);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R14 taken", {31'b0, taken}, 0);
    chk("R14 fatal", {31'b0, fatal}, 0);
    chk("R14 msr", msr, 0);
    chk("R14 esr", esr, 0);
    chk("R14 btr", btr, 0);
    chk("R14 ear", ear, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: exception ignored when support is off
    wr_msr(32'h0000_2802);
    exc = 1; cause = 5'd7; pc = 32'h40;
    @(negedge clk);
    clr_req();
    chk("R10 no entry", {31'b0, n_taken}, 0);
    chk("R10 msr kept", n_msr, 32'h0000_2802);
    chk("R10 esr kept", n_esr, 0);

    // R2/R3/R8: interrupt gating sweep
    for (int c = 0; c < 32; c++) begin
      logic [31:0] m;
      logic take;
      m = ({31'b0, c[0]} << 1) | ({31'b0, c[1]} << 9) | ({31'b0, c[2]} << 3)
        | ({31'b0, c[3]} << 11) | ({31'b0, c[4]} << 13);
      wr_msr(m);
      irq = 1; pc = 32'h100 + 32'(c) * 4; ds = c[3]; imm = c[4];
      take = c[0] && !c[1] && !c[2] && !c[3] && !c[4];
      @(negedge clk);
      clr_req();
      chk("R2 irq taken", {31'b0, taken}, {31'b0, take});
      if (take) begin
        chk("R1 irq vector", pc_o, BASE + 32'h10);
        chk("R3 irq ra idx", {27'b0, ra_idx}, 14);
        chk("R3 irq ra val", ra_val, pc);
        chk("R8 irq msr", msr, shift_mode(m & ~32'h2));
        @(negedge clk);
        chk("R9 single pulse", {31'b0, taken}, 0);
      end else begin
        chk("R2 msr unchanged", msr, m);
      end
    end

    // R4: break entry
    wr_msr(32'h0000_2802);
    brk = 1; pc = 32'h200;
    @(negedge clk);
    clr_req();
    chk("R4 taken", {31'b0, taken}, 1);
    chk("R1 brk vector", pc_o, BASE + 32'h18);
    chk("R4 ra idx", {27'b0, ra_idx}, 16);
    chk("R4 ra val", ra_val, 32'h200);
    chk("R4 msr", msr, shift_mode(32'h0000_280A));

    // R5: hardware exception with and without delay slot
    for (int c = 0; c < 4; c++) begin
      logic [31:0] e;
      wr_msr(32'h0000_0800);
      exc = 1; cause = 5'(3 + c * 5); ds = c[0]; pc = 32'h300 + 32'(c) * 8;
      bt = 32'hB000 + 32'(c);
      @(negedge clk);
      e = {19'b0, c[0], 7'b0, 5'(3 + c * 5)};
      if (c[0]) exp_btr = 32'hB000 + 32'(c);
      clr_req();
      chk("R1 exc vector", pc_o, BASE + 32'h20);
      chk("R5 ra idx", {27'b0, ra_idx}, 17);
      chk("R5 ra val", ra_val, pc + 4);
      chk("R5 esr", esr, e);
      chk("R5 btr", btr, exp_btr);
      chk("R5 msr", msr, shift_mode(32'h0000_0A00));
    end

    // R6/R7: MMU fault sweep over kind, access, rewind state
    for (int k = 0; k < 2; k++)
      for (int a = 0; a < 3; a++)
        for (int s = 0; s < 4; s++) begin
          logic [31:0] r, e;
          wr_msr(32'h0000_2000);
          mmu = 1; miss = k[0]; acc = 2'(a);
          addr = 32'hA000_0000 + 32'(k * 64 + a * 16 + s);
          pc = 32'h1000 + 32'(s) * 16;
          bt = 32'hC000 + 32'(s);
          imm  = (s == 1);
          ds   = (s >= 2);
          bimm = (s == 3);
          r = (s == 3) ? pc - 8 : (s == 0) ? pc : pc - 4;
          e = 32'(16 + 2 * k + (a == 2 ? 1 : 0)) | ((a == 1) ? 32'h400 : 0) | ((s >= 2) ? 32'h1000 : 0);
          if (s >= 2) exp_btr = bt;
          @(negedge clk);
          clr_req();
          chk("R6 taken", {31'b0, taken}, 1);
          chk("R6 ra val", ra_val, r);
          chk("R7 esr", esr, e);
          chk("R7 ear", ear, addr);
          chk("R6 btr", btr, exp_btr);
          chk("R8 mmu msr", msr, shift_mode(32'h0000_2200));
        end

    // R11: priority
    wr_msr(32'h0000_0002);
    mmu = 1; exc = 1; brk = 1; irq = 1; acc = 2'd0; miss = 0; pc = 32'h500;
    @(negedge clk);
    clr_req();
    chk("R11 mmu first", ra_val, 32'h500);
    chk("R11 mmu esr", esr, 32'd16);
    wr_msr(32'h0000_0002);
    exc = 1; brk = 1; irq = 1; cause = 5'd9; pc = 32'h600;
    @(negedge clk);
    clr_req();
    chk("R11 exc second", ra_val, 32'h604);
    chk("R11 exc esr", esr, 32'd9);
    wr_msr(32'h0000_0002);
    brk = 1; irq = 1; pc = 32'h700;
    @(negedge clk);
    clr_req();
    chk("R11 brk third", {27'b0, ra_idx}, 16);
    chk("R11 ie kept", msr, 32'h0000_000A);

    // R13: entry overrides a simultaneous write
    wr_msr(32'h0000_0002);
    irq = 1; pc = 32'h800; we = 1; wdata = 32'h0000_FFFF;
    @(negedge clk);
    clr_req();
    chk("R13 entry wins", msr, 32'h0);

    // R12: nested MMU fault
    wr_msr(32'h0);
    mmu = 1; pc = 32'h900; addr = 32'h1234;
    @(negedge clk);
    clr_req();
    chk("R12 first entry", {31'b0, taken}, 1);
    chk("R12 no fatal yet", {31'b0, fatal}, 0);
    mmu = 1; pc = 32'h904; addr = 32'h5678;
    @(negedge clk);
    clr_req();
    chk("R12 no reentry", {31'b0, taken}, 0);
    chk("R12 fatal set", {31'b0, fatal}, 1);
    chk("R12 ear kept", ear, 32'h1234);
    wr_msr(32'h0);
    chk("R12 fatal sticky", {31'b0, fatal}, 1);
    mmu = 1; pc = 32'hA00;
    @(negedge clk);
    clr_req();
    chk("R12 entry after clear", {31'b0, taken}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule